// File: doc/BRIEF.md
# Partial Array Self-Refresh Controller

This block governs self-refresh for a pseudo-static memory of 2^ADDR_W words (2M words at the default width). A write-only configuration word carries a 3-bit window code that chooses which part of the array stays refreshed: all of it, nothing, or the bottom or top half, quarter or eighth. The block decodes that code into an address window and steps a refresh row counter through that window only, wrapping from its top row back to its base. A newly written code comes into force at the next refresh tick.

A sleep input (active low) puts the block into partial-refresh state once it has stayed low for longer than a set time, counted in clock cycles derived from the clock frequency. Entry is allowed only when an externally held deep-power-down disable bit is set. While the block is in that state, read and write commands are held back from the array. Raising the sleep input leaves the state at once. In normal operation every command is passed on, and an access whose address lies outside the refreshed window is marked as not retained.

Top module: `psr_ctrl`

## Requirements
- R1: After reset the window code is 000 (whole array), `ref_req`, `in_psr` and `rsv_err` are 0, and `ref_row` is 0.
- R2: `not_kept` is 1 exactly when a command is passed to the array (`arr_valid`) and its address lies outside the window in force. With N = 2^ADDR_W the windows are: 000 all of [0, N-1]; 001 [0, N/2-1]; 010 [0, N/4-1]; 011 [0, N/8-1]; 100 empty; 101 [N/2, N-1]; 110 [3N/4, N-1]; 111 [7N/8, N-1].
- R3: A refresh tick occurs every REF_DIV cycles. At a tick where the window does not change and is not empty, `ref_req` pulses high for one cycle with `ref_row` holding the current row. Rows ascend by one and wrap from the window's top to its base.
- R4: While the window code in force is 100, `ref_req` stays 0.
- R5: A written code comes into force at the next refresh tick. That tick issues no request, and the next request carries the new window's base row.
- R6: The code sits in `cfg_wdata[2:0]`; bits 3 and up are reserved. A write with any reserved bit set leaves the code unchanged and sets `rsv_err`. A write with all reserved bits clear loads the code and clears `rsv_err`.
- R7: With `deep_pd_off` at 1, `in_psr` rises after `sleep_n` has been sampled low on SLEEP_CYC+1 consecutive rising edges, where SLEEP_CYC = ceil(SLEEP_NS * CLK_KHZ / 10^6).
- R8: Sampling `sleep_n` high before the count completes clears the count, and a fresh low period must again last the full time.
- R9: While `deep_pd_off` is 0, a low `sleep_n` never leads to partial-refresh state.
- R10: While `in_psr` is 1, `arr_valid` and `not_kept` are 0 whatever `cmd_valid` does. Outside that state, `arr_valid` follows `cmd_valid`.
- R11: `in_psr` falls in the same cycle that `sleep_n` goes high, and commands pass again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration word: window code in [2:0], reserved above |
| deep_pd_off | input | 1 | Deep-power-down disable bit from the companion register |
| sleep_n | input | 1 | Sleep request, active low |
| cmd_valid | input | 1 | Read or write command present |
| cmd_addr | input | ADDR_W | Word address of the command |
| arr_valid | output | 1 | Command forwarded to the array |
| not_kept | output | 1 | Forwarded command addresses an unrefreshed region |
| in_psr | output | 1 | Partial-refresh state active |
| ref_req | output | 1 | Refresh request pulse |
| ref_row | output | ADDR_W | Row of the current refresh request |
| rsv_err | output | 1 | Last configuration write had reserved bits set |

## Verification
The bench builds the block with an 8-bit address, an 8-bit configuration word, a refresh tick every two cycles and a 200 ns sleep time at 50 MHz, so the sleep threshold is 10 cycles. With only 256 addresses, every address is swept against every window code, so each window edge is hit exactly, and the wrap of the row counter in every window fits within a few hundred cycles. The short threshold brings the exact entry edge, an abort one cycle before it, and the deep-power-down gate within a short run.

// File: rtl/psr_pkg.sv
package psr_pkg;

   localparam int CODE_W = 3;
   localparam int NCODE  = 1 << CODE_W;

   typedef enum logic [CODE_W-1:0] {
      WIN_FULL = 3'd0,
      WIN_LO2  = 3'd1,
      WIN_LO4  = 3'd2,
      WIN_LO8  = 3'd3,
      WIN_NONE = 3'd4,
      WIN_HI2  = 3'd5,
      WIN_HI4  = 3'd6,
      WIN_HI8  = 3'd7
   } win_code_e;

endpackage

// File: rtl/psr_window.sv
module psr_window
   import psr_pkg::*;
#(
   parameter int ADDR_W = 21
) (
   input  win_code_e            code,
   output logic [ADDR_W-1:0]    lo,
   output logic [ADDR_W-1:0]    hi,
   output logic                 en
);

   localparam logic [ADDR_W-1:0] ONES = '1;

   if (ADDR_W < 3) begin : g_bad_width
      $error("psr_window: ADDR_W must be at least 3");
   end

   function automatic logic [ADDR_W-1:0] base_of(input int c);
      case (c)
         5:       return ONES ^ (ONES >> 1);
         6:       return ONES ^ (ONES >> 2);
         7:       return ONES ^ (ONES >> 3);
         default: return '0;
      endcase
   endfunction

   function automatic logic [ADDR_W-1:0] top_of(input int c);
      case (c)
         1:       return ONES >> 1;
         2:       return ONES >> 2;
         3:       return ONES >> 3;
         default: return ONES;
      endcase
   endfunction

   logic [ADDR_W-1:0] lo_tab [NCODE];
   logic [ADDR_W-1:0] hi_tab [NCODE];
   logic [NCODE-1:0]  en_tab;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      assign lo_tab[c] = base_of(c);
      assign hi_tab[c] = top_of(c);
      assign en_tab[c] = (c != int'(WIN_NONE));
   end

   assign lo = lo_tab[code];
   assign hi = hi_tab[code];
   assign en = en_tab[code];

endmodule

// File: rtl/psr_cfg_reg.sv
module psr_cfg_reg
   import psr_pkg::*;
#(
   parameter int CFG_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output win_code_e        code,
   output logic             rsv_err
);

   if (CFG_W <= CODE_W) begin : g_bad_cfg
      $error("psr_cfg_reg: CFG_W must leave at least one reserved bit");
   end

   logic rsv_hit;
   assign rsv_hit = |wdata[CFG_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= WIN_FULL;
         rsv_err <= 1'b0;
      end else if (we) begin
         if (rsv_hit) begin
            rsv_err <= 1'b1;
         end else begin
            rsv_err <= 1'b0;
            code    <= win_code_e'(wdata[CODE_W-1:0]);
         end
      end
   end

   // R6: a rejected write keeps the code and raises the flag
   p_rsv_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && rsv_hit) |=> ($stable(code) && rsv_err));

endmodule

// File: rtl/psr_sleep_timer.sv
module psr_sleep_timer #(
   parameter int LIMIT = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_n,
   input  logic dpd_off,
   output logic psr_q
);

   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("psr_sleep_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         psr_q <= 1'b0;
      end else if (sleep_n) begin
         cnt   <= '0;
         psr_q <= 1'b0;
      end else if (!psr_q) begin
         if (!dpd_off) begin
            cnt <= '0;
         end else if (cnt == CW'(LIMIT)) begin
            psr_q <= 1'b1;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // R7: entry only after the full count
   p_enter_timed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psr_q) |-> ($past(cnt) == CW'(LIMIT)));

   // R8: a high sample clears both count and state
   p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_n |=> (cnt == '0 && !psr_q));

   // R9: no entry without the disable bit
   p_dpd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!psr_q && !dpd_off) |=> !psr_q);

endmodule

// File: rtl/psr_refresh.sv
module psr_refresh
   import psr_pkg::*;
#(
   parameter int ADDR_W  = 21,
   parameter int REF_DIV = 390
) (
   input  logic              clk,
   input  logic              rst_n,
   input  win_code_e         cfg_code,
   output logic [ADDR_W-1:0] act_lo,
   output logic [ADDR_W-1:0] act_hi,
   output logic              act_en,
   output logic              ref_req,
   output logic [ADDR_W-1:0] ref_row
);

   localparam int DIV_W = $clog2(REF_DIV);

   if (REF_DIV < 2) begin : g_bad_div
      $error("psr_refresh: REF_DIV must be at least 2");
   end

   win_code_e         act_code;
   logic [DIV_W-1:0]  div;
   logic              tick;
   logic              reload_q;
   logic [ADDR_W-1:0] row;

   psr_window #(.ADDR_W(ADDR_W)) u_win (
      .code (act_code),
      .lo   (act_lo),
      .hi   (act_hi),
      .en   (act_en)
   );

   assign tick = (div == DIV_W'(REF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div <= '0;
      end else if (tick) begin
         div <= '0;
      end else begin
         div <= div + DIV_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_code <= WIN_FULL;
         reload_q <= 1'b0;
         row      <= '0;
         ref_req  <= 1'b0;
         ref_row  <= '0;
      end else begin
         reload_q <= 1'b0;
         ref_req  <= 1'b0;
         if (reload_q) begin
            row <= act_lo;
         end
         if (tick) begin
            if (cfg_code != act_code) begin
               act_code <= cfg_code;
               reload_q <= 1'b1;
            end else if (act_en) begin
               ref_req <= 1'b1;
               ref_row <= row;
               row     <= (row == act_hi) ? act_lo : row + ADDR_W'(1);
            end
         end
      end
   end

   // R3: every request lies inside the window in force
   p_req_in_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (ref_row >= act_lo && ref_row <= act_hi));

   // R3: requests are single-cycle pulses
   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |=> !ref_req);

   // R4: an empty window never requests refresh
   p_none_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_en |-> !ref_req);

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
   import psr_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int CFG_W    = 21,
   parameter int CLK_KHZ  = 50_000,
   parameter int SLEEP_NS = 10_000,
   parameter int REF_DIV  = 390
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              deep_pd_off,
   input  logic              sleep_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              arr_valid,
   output logic              not_kept,
   output logic              in_psr,
   output logic              ref_req,
   output logic [ADDR_W-1:0] ref_row,
   output logic              rsv_err
);

   localparam int SLEEP_CYC = (SLEEP_NS * CLK_KHZ + 999_999) / 1_000_000;

   if (SLEEP_CYC < 1) begin : g_bad_sleep
      $error("psr_ctrl: sleep time rounds to zero cycles");
   end

   win_code_e         cfg_code;
   logic [ADDR_W-1:0] act_lo;
   logic [ADDR_W-1:0] act_hi;
   logic              act_en;
   logic              psr_q;

   psr_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .code    (cfg_code),
      .rsv_err (rsv_err)
   );

   psr_refresh #(.ADDR_W(ADDR_W), .REF_DIV(REF_DIV)) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_code (cfg_code),
      .act_lo   (act_lo),
      .act_hi   (act_hi),
      .act_en   (act_en),
      .ref_req  (ref_req),
      .ref_row  (ref_row)
   );

   psr_sleep_timer #(.LIMIT(SLEEP_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_n (sleep_n),
      .dpd_off (deep_pd_off),
      .psr_q   (psr_q)
   );

   assign in_psr    = psr_q & ~sleep_n;
   assign arr_valid = cmd_valid & ~in_psr;
   assign not_kept  = arr_valid &
                      (~act_en | (cmd_addr < act_lo) | (cmd_addr > act_hi));

   // R2: a not-retained mark only accompanies a forwarded command
   p_flag_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      not_kept |-> arr_valid);

endmodule

// File: tb/tb_psr_ctrl.sv
module tb_psr_ctrl;

   localparam int AW      = 8;
   localparam int CW      = 8;
   localparam int KHZ     = 50_000;
   localparam int SNS     = 200;
   localparam int DIV     = 2;
   localparam int LIM     = 10;
   localparam int N       = 1 << AW;
   localparam int PHASE   = 600;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          cfg_we = 0;
   logic [CW-1:0] cfg_wdata = '0;
   logic          deep_pd_off = 0;
   logic          sleep_n = 1;
   logic          cmd_valid = 0;
   logic [AW-1:0] cmd_addr = '0;
   logic          arr_valid, not_kept, in_psr, ref_req, rsv_err;
   logic [AW-1:0] ref_row;

   psr_ctrl #(.ADDR_W(AW), .CFG_W(CW), .CLK_KHZ(KHZ), .SLEEP_NS(SNS),
              .REF_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .deep_pd_off(deep_pd_off), .sleep_n(sleep_n), .cmd_valid(cmd_valid),
      .cmd_addr(cmd_addr), .arr_valid(arr_valid), .not_kept(not_kept),
      .in_psr(in_psr), .ref_req(ref_req), .ref_row(ref_row), .rsv_err(rsv_err)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;
   int addr_ctr = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int mlo(input int c);
      case (c)
         5: return N / 2;
         6: return 3 * N / 4;
         7: return 7 * N / 8;
         default: return 0;
      endcase
   endfunction

   function automatic int mhi(input int c);
      case (c)
         1: return N / 2 - 1;
         2: return N / 4 - 1;
         3: return N / 8 - 1;
         4: return -1;
         default: return N - 1;
      endcase
   endfunction

   // behavioural reference model
   int m_div, m_code, m_act, m_row, m_refrow, m_cnt;
   bit m_refq, m_err, m_psr, tick;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 0; m_code = 0; m_act = 0; m_row = 0; m_refrow = 0;
         m_cnt = 0; m_refq = 0; m_err = 0; m_psr = 0;
      end else begin
         tick = (m_div == DIV - 1);
         m_div = tick ? 0 : m_div + 1;
         m_refq = 0;
         if (tick) begin
            if (m_code != m_act) begin
               m_act = m_code;
               m_row = mlo(m_act);
            end else if (m_act != 4) begin
               m_refq = 1;
               m_refrow = m_row;
               m_row = (m_row == mhi(m_act)) ? mlo(m_act) : m_row + 1;
            end
         end
         if (cfg_we) begin
            if ((int'(cfg_wdata) >> 3) != 0) m_err = 1;
            else begin
               m_err = 0;
               m_code = int'(cfg_wdata) & 7;
            end
         end
         if (sleep_n) begin
            m_cnt = 0; m_psr = 0;
         end else if (!m_psr) begin
            if (!deep_pd_off) m_cnt = 0;
            else if (m_cnt == LIM) m_psr = 1;
            else m_cnt++;
         end
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_psr, e_arr, e_nk;
         int a;
         a = int'(cmd_addr);
         e_psr = m_psr && !sleep_n;
         e_arr = cmd_valid && !e_psr;
         e_nk  = e_arr && (m_act == 4 || a < mlo(m_act) || a > mhi(m_act));
         chk("R3 ref_req", int'(ref_req), int'(m_refq));
         if (m_refq) chk("R3 ref_row", int'(ref_row), m_refrow);
         chk("R2 not_kept", int'(not_kept), int'(e_nk));
         chk("R10 arr_valid", int'(arr_valid), int'(e_arr));
         chk("R7 in_psr", int'(in_psr), int'(e_psr));
         chk("R6 rsv_err", int'(rsv_err), int'(m_err));
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
      cmd_addr  = AW'(addr_ctr);
      cmd_valid = (addr_ctr % 3) != 2;
      addr_ctr++;
   endtask

   task automatic wr_cfg(input logic [CW-1:0] d);
      @(posedge clk);
      #2;
      cfg_we = 1; cfg_wdata = d;
      @(posedge clk);
      #2;
      cfg_we = 0; cfg_wdata = '0;
   endtask

   task automatic summary();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100_000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      int seen;
      int used;
      int codes [8] = '{1, 2, 3, 4, 5, 6, 7, 0};
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1;
      cmd_valid = 1; cmd_addr = AW'(N - 1);
      #1;
      // R1: reset state
      chk("R1 ref_req", int'(ref_req), 0);
      chk("R1 ref_row", int'(ref_row), 0);
      chk("R1 in_psr", int'(in_psr), 0);
      chk("R1 rsv_err", int'(rsv_err), 0);
      chk("R1 not_kept full window", int'(not_kept), 0);

      foreach (codes[i]) begin
         int c;
         c = codes[i];
         wr_cfg(CW'(c));
         used = 0;
         if (c == 4) begin
            seen = 0;
            repeat (PHASE) begin
               step();
               if (ref_req) seen++;
            end
            chk("R4 requests under empty window", seen, 0);
         end else begin
            repeat (DIV) step();
            used = DIV;
            seen = 0;
            while (seen == 0 && used < 8 * DIV) begin
               step();
               used++;
               if (ref_req) begin
                  seen = 1;
                  chk("R5 first row after change", int'(ref_row), mlo(c));
               end
            end
            chk("R5 request after change", seen, 1);
            repeat (PHASE - used) step();
         end
      end

      // R6: reserved bits set -> rejected, code stays 000
      wr_cfg(8'b0000_1001);
      #1;
      chk("R6 flag after reserved write", int'(rsv_err), 1);
      repeat (2 * DIV + 1) step();
      cmd_valid = 1; cmd_addr = AW'(N - 1);
      #1;
      chk("R6 code kept after reserved write", int'(not_kept), 0);
      wr_cfg(8'b0000_0001);
      #1;
      chk("R6 flag cleared by clean write", int'(rsv_err), 0);
      repeat (2 * DIV + 1) step();
      cmd_valid = 1; cmd_addr = AW'(N - 1);
      #1;
      chk("R6 clean write loads code", int'(not_kept), 1);
      wr_cfg(8'b0000_0000);
      repeat (2 * DIV + 1) step();

      // R9: disable bit clear blocks entry
      deep_pd_off = 0;
      sleep_n = 0;
      repeat (3 * LIM) step();
      #1;
      chk("R9 no entry with disable bit clear", int'(in_psr), 0);
      step();
      sleep_n = 1;
      deep_pd_off = 1;
      step();

      // R8: abort one edge before expiry, then a fresh low period
      sleep_n = 0;
      repeat (LIM) step();
      #1;
      chk("R8 not entered before expiry", int'(in_psr), 0);
      sleep_n = 1;
      step();
      sleep_n = 0;
      repeat (LIM) step();
      #1;
      chk("R8 count restarted after abort", int'(in_psr), 0);
      // R7: one more low edge completes the count
      step();
      #1;
      chk("R7 entry after full low time", int'(in_psr), 1);

      // R10: commands held back while in the state
      cmd_valid = 1; cmd_addr = AW'(N - 1);
      #1;
      chk("R10 command blocked", int'(arr_valid), 0);
      chk("R10 no not_kept while blocked", int'(not_kept), 0);
      repeat (5) step();
      cmd_valid = 1;
      #1;
      chk("R10 still blocked", int'(arr_valid), 0);

      // R11: immediate exit
      sleep_n = 1;
      #1;
      chk("R11 exit same cycle", int'(in_psr), 0);
      chk("R11 commands pass again", int'(arr_valid), 1);
      repeat (20) step();

      summary();
   end

endmodule